// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is an I2C target that gives a bus master access to a 256-byte on-chip byte store. SCL and SDA are sampled by a much faster system clock. The block recognises start and stop conditions at any point on the bus. It checks a 7-bit device address, then takes a word address and writes the data bytes that follow, or it sends stored bytes back to the master.

SDA is driven open-drain style. The single output `sda_oe` pulls the line low when it is 1. An internal byte pointer persists between transactions. A read that does not set a word address first continues from where the previous access stopped.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, every byte of the store reads 0x00 and the byte pointer is 0.
- R2: Nothing on the bus is acted upon until a start is seen (SDA falls while SCL is high). Bytes clocked without a start get no acknowledge.
- R3: A stop (SDA rises while SCL is high) ends any command and releases SDA. Later bytes clocked without a new start get no acknowledge.
- R4: Bytes travel MSB first. The eighth bit of the first byte after a start is R/W (1 = read). When the upper seven bits equal the `DEV_ADDR` parameter (default 0x50), the slave pulls SDA low during the ninth clock.
- R5: A device byte that does not match gets no acknowledge. The slave then ignores the bus until the next start: no byte is acknowledged, nothing is written and the pointer does not move.
- R6: In a write command, the second byte loads the pointer, and each later byte is stored at the pointer. Every one of these bytes is acknowledged.
- R7: The pointer advances by one after each byte written or sent, and wraps from 255 to 0.
- R8: In a read command, the slave drives the byte at the pointer, changes `sda_oe` only while SCL is low, and releases SDA for the ninth clock.
- R9: When the master pulls SDA low on the ninth clock, the next byte follows. When the master leaves SDA high on the ninth clock, the slave stays silent until a stop or a start.
- R10: A read command issued straight after a start reads from the current pointer.
- R11: A start seen in the middle of a byte restarts device-address decoding, and the partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (resolved level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench goes after these corner cases:

- **Pointer wrap.** A burst writes and reads across the top of the array. A pointer that saturated, or did not wrap, would return the wrong byte after 0xFF.
- **Master NACK.** The bench clocks a further byte after the master NACKs. A slave that kept streaming would pull the line low where the bench expects it released.
- **Wrong device address.** A byte follows a non-matching address. A slave that woke up on it would acknowledge the byte or corrupt the pointer.
- **Restart mid-byte.** A repeated start cuts a data byte in half. A design that kept counting bits would misread the next address, or would store a half-received byte.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_WADDR,
        PH_WADDR_ACK,
        PH_WDATA,
        PH_WDATA_ACK,
        PH_TX,
        PH_MACK,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic [7:0] tx;
        logic       oe;
        logic       rd;
        logic       mnack;
    } ctrl_t;

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2cmem_edges.sv
module i2cmem_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cmem_array.sv
module i2cmem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R6: a store never takes an undefined byte or address
    a_r6_write_known: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (!$isunknown(wdata) && !$isunknown(waddr)));
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import i2cmem_pkg::*;

    localparam int                DATA_W   = 8;
    localparam int                N_LINES  = 2;
    localparam logic [ADDR_W-1:0] PTR_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] syn_lines;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2cmem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[g]),
            .q     (syn_lines[g])
        );
    end

    assign scl_s = syn_lines[1];
    assign sda_s = syn_lines[0];

    i2cmem_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    ctrl_t             c_d, c_q;
    logic [ADDR_W-1:0] ptr_d, ptr_q;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    i2cmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (ptr_q),
        .wdata (c_q.shreg),
        .raddr (ptr_q),
        .rdata (mem_rdata)
    );

    always_comb begin
        c_d    = c_q;
        ptr_d  = ptr_q;
        mem_we = 1'b0;
        if (bus_start) begin
            c_d.phase = PH_DEV;
            c_d.cnt   = '0;
            c_d.oe    = 1'b0;
        end else if (bus_stop) begin
            c_d.phase = PH_IDLE;
            c_d.cnt   = '0;
            c_d.oe    = 1'b0;
        end else begin
            case (c_q.phase)
                PH_DEV, PH_WADDR, PH_WDATA: begin
                    if (scl_rise && c_q.cnt < BITS_PER_BYTE) begin
                        c_d.shreg = {c_q.shreg[6:0], sda_s};
                        c_d.cnt   = c_q.cnt + 4'd1;
                    end else if (scl_fall && c_q.cnt == BITS_PER_BYTE) begin
                        c_d.cnt = '0;
                        if (c_q.phase == PH_DEV) begin
                            if (c_q.shreg[7:1] == DEV_ADDR) begin
                                c_d.rd    = c_q.shreg[0];
                                c_d.oe    = 1'b1;
                                c_d.phase = PH_DEV_ACK;
                            end else begin
                                c_d.phase = PH_HOLD;
                            end
                        end else if (c_q.phase == PH_WADDR) begin
                            ptr_d     = c_q.shreg[ADDR_W-1:0];
                            c_d.oe    = 1'b1;
                            c_d.phase = PH_WADDR_ACK;
                        end else begin
                            mem_we    = 1'b1;
                            ptr_d     = ptr_q + PTR_STEP;
                            c_d.oe    = 1'b1;
                            c_d.phase = PH_WDATA_ACK;
                        end
                    end
                end
                PH_DEV_ACK, PH_WADDR_ACK, PH_WDATA_ACK: begin
                    if (scl_fall) begin
                        c_d.oe  = 1'b0;
                        c_d.cnt = '0;
                        if (c_q.phase == PH_DEV_ACK && c_q.rd) begin
                            c_d.tx    = mem_rdata;
                            c_d.oe    = ~mem_rdata[7];
                            c_d.phase = PH_TX;
                        end else if (c_q.phase == PH_DEV_ACK) begin
                            c_d.phase = PH_WADDR;
                        end else begin
                            c_d.phase = PH_WDATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise && c_q.cnt < BITS_PER_BYTE) begin
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (c_q.cnt == BITS_PER_BYTE) begin
                            c_d.oe    = 1'b0;
                            c_d.cnt   = '0;
                            ptr_d     = ptr_q + PTR_STEP;
                            c_d.phase = PH_MACK;
                        end else begin
                            c_d.tx = {c_q.tx[6:0], 1'b0};
                            c_d.oe = ~c_q.tx[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        c_d.mnack = sda_s;
                    end else if (scl_fall) begin
                        if (!c_q.mnack) begin
                            c_d.tx    = mem_rdata;
                            c_d.oe    = ~mem_rdata[7];
                            c_d.cnt   = '0;
                            c_d.phase = PH_TX;
                        end else begin
                            c_d.phase = PH_HOLD;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.phase <= PH_IDLE;
            c_q.cnt   <= '0;
            c_q.shreg <= '0;
            c_q.tx    <= '0;
            c_q.oe    <= 1'b0;
            c_q.rd    <= 1'b0;
            c_q.mnack <= 1'b1;
            ptr_q     <= '0;
        end else begin
            c_q   <= c_d;
            ptr_q <= ptr_d;
        end
    end

    assign sda_oe = c_q.oe;

    // R8: the SDA drive only changes after SCL was seen low
    a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.oe) |-> !$past(scl_s));

    // R3: an idle slave never holds the line
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_IDLE) |-> !sda_oe);

    // R4: an acknowledge starts only after a full eight-bit byte
    a_r4_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(c_q.oe) && c_q.phase != PH_TX && c_q.phase != PH_MACK)
            |-> ($past(c_q.cnt) == BITS_PER_BYTE));

    // R9: the silent hold after a read is entered only on a master NACK
    a_r9_hold_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_HOLD && $past(c_q.phase) == PH_MACK) |-> $past(c_q.mnack));

    // R7: each byte sent moves the pointer by exactly one, modulo the depth
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(c_q.phase) == PH_TX && c_q.phase == PH_MACK)
            |-> (ptr_q == $past(ptr_q) + PTR_STEP));
endmodule

// File: tb/i2cmem_slave_tb.sv
module i2cmem_slave_tb;
    localparam int         QTR = 4;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int    checks = 0;
    int    errors = 0;
    logic  exp_oe = 1'b0;
    string exp_tag = "R1";
    logic [7:0] mem_m [256];
    int    ptr_m = 0;

    always #10 clk = ~clk;

    i2cmem_slave u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    // per-clock comparison of the slave drive against the bench model
    always @(negedge clk) begin
        if (rst_n && scl_m) begin
            checks++;
            if (sda_oe !== exp_oe) begin
                errors++;
                $display("FAIL %s sda_oe actual %b expected %b", exp_tag, sda_oe, exp_oe);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, input logic e_oe, input string tag, output logic seen);
        wait_q();
        sda_m   = b;
        exp_oe  = e_oe;
        exp_tag = tag;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        seen = sda_line;
        wait_q();
        scl_m = 1'b0;
    endtask

    task automatic send_start(input string tag);
        wait_q();
        sda_m = 1'b1; exp_oe = 1'b0; exp_tag = tag;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
    endtask

    task automatic send_stop(input string tag);
        wait_q();
        sda_m = 1'b0; exp_oe = 1'b0; exp_tag = tag;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input string tag);
        logic seen;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], 1'b0, tag, seen);
        clock_bit(1'b1, ack, tag, seen);
        check({tag, " ack level"}, int'(seen), int'(!ack));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic drive, input logic mack, input string tag);
        logic       seen;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, drive & ~exp[i], tag, seen);
            got[i] = seen;
        end
        check({tag, " read byte"}, int'(got), int'(exp));
        clock_bit(!mack, 1'b0, tag, seen);
    endtask

    task automatic read_burst(input int n, input string tag);
        send_byte({DEV, 1'b1}, 1'b1, "R4");
        for (int k = 0; k < n; k++) begin
            recv_byte(mem_m[ptr_m], 1'b1, (k < n - 1), tag);
            ptr_m = (ptr_m + 1) % 256;
        end
        send_stop(tag);
    endtask

    task automatic write_seq(input logic [7:0] addr, input logic [31:0] data, input int n, input string tag);
        send_start("R2");
        send_byte({DEV, 1'b0}, 1'b1, "R4");
        send_byte(addr, 1'b1, tag);
        ptr_m = addr;
        for (int k = 0; k < n; k++) begin
            send_byte(data[8*k +: 8], 1'b1, tag);
            mem_m[ptr_m] = data[8*k +: 8];
            ptr_m = (ptr_m + 1) % 256;
        end
        send_stop(tag);
    endtask

    task automatic read_at(input logic [7:0] addr, input int n, input string tag);
        send_start("R2");
        send_byte({DEV, 1'b0}, 1'b1, "R4");
        send_byte(addr, 1'b1, "R6");
        ptr_m = addr;
        send_start("R11");
        read_burst(n, tag);
    endtask

    initial begin
        logic seen;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        check("R1 sda_oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 sda_oe after reset", int'(sda_oe), 0);

        // R1 / R10: first read comes from pointer 0 of a cleared store
        send_start("R2");
        read_burst(1, "R10");

        // R2: a correct device byte without a start is not acknowledged
        wait_q();
        scl_m = 1'b0;
        send_byte({DEV, 1'b0}, 1'b0, "R2");
        send_stop("R2");

        // R6 / R8 / R9: burst write, then random read ending in NACK
        write_seq(8'h10, 32'h0044_3322, 3, "R6");
        read_at(8'h10, 3, "R8");

        // R7: writes and reads across the top of the array
        write_seq(8'hFE, 32'hD4C3_B2A1, 4, "R7");
        read_at(8'hFE, 3, "R7");

        // R10: current-pointer read picks up at 0x01
        send_start("R2");
        read_burst(1, "R10");

        // R5: wrong device address, then a byte that must be ignored
        send_start("R2");
        send_byte({7'h51, 1'b0}, 1'b0, "R5");
        send_byte(8'h99, 1'b0, "R5");
        send_stop("R5");
        send_start("R2");
        read_burst(1, "R5");

        // R9: after a NACK the slave stays off the line
        send_start("R2");
        send_byte({DEV, 1'b1}, 1'b1, "R4");
        recv_byte(mem_m[ptr_m], 1'b1, 1'b0, "R9");
        ptr_m = (ptr_m + 1) % 256;
        recv_byte(8'hFF, 1'b0, 1'b0, "R9");
        send_stop("R9");

        // R11: restart in the middle of a data byte
        send_start("R2");
        send_byte({DEV, 1'b0}, 1'b1, "R4");
        send_byte(8'h11, 1'b1, "R11");
        ptr_m = 8'h11;
        for (int i = 0; i < 4; i++) clock_bit(1'b0, 1'b0, "R11", seen);
        send_start("R11");
        read_burst(1, "R11");

        // R3: a stop ends the command; later bytes without a start get nothing
        send_start("R2");
        send_byte({DEV, 1'b0}, 1'b1, "R4");
        send_stop("R3");
        wait_q();
        scl_m = 1'b0;
        send_byte(8'h05, 1'b0, "R3");
        send_stop("R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule